// File: doc/BRIEF.md
# Indirect-Offset Effective Address and Word Load Unit

This block works out the operand address for two displacement addressing modes of a 16-bit microcontroller core and then loads one 16-bit word from that address. In long-register mode it picks one of four 32-bit long registers, adds a sign-extended 8-bit displacement, and keeps the low 24 bits as the address. In program-relative mode it forms the low 16 address bits as instruction address + 4 + a 16-bit displacement, and takes the top 8 bits from the program bank register.

The bias of 4 applies whatever the instruction length is. This includes the decrement-and-branch, compare-and-branch and immediate-move forms. It is never "next instruction address plus displacement".

After a request is accepted, the block registers the address and reads two bytes through a byte-wide memory port. The low byte comes from the address and the high byte from the address plus one. The block then shifts the accumulator. The old low half moves up, and the fetched word enters the low half. A one-cycle done pulse marks the update. A new request is accepted only while the block is idle.

Top module: `ea_fetch_unit`

## Requirements
- R1: With `mode`=0, `ea` equals the low 24 bits of long register `reg_idx` plus the sign-extended `disp8`. Register n occupies `long_regs[32n+31:32n]`.
- R2: With `mode`=1, `ea[15:0]` equals (`instr_addr` + 4 + `disp16`) mod 65536. `ea[23:16]` equals `prog_bank`, and the 16-bit sum never carries into it.
- R3: After acceptance, exactly two memory requests are issued on consecutive cycles. The first request is at `ea`, and the second is at (`ea` + 1) mod 2^24.
- R4: `word_out` equals {byte read at ea+1, byte read at ea}. Memory returns `mem_rdata` one cycle after each request.
- R5: When `done` is high, `acc_out` equals {`acc_in[15:0]` sampled at acceptance, `word_out`}.
- R6: `done` is a single-cycle pulse. It is high in the cycle after the third rising edge that follows the accepting edge.
- R7: `ea` is registered at acceptance and stays stable while `busy` is high. A `start` seen while busy is ignored, and so are changes on the operand inputs.
- R8: After reset, `done`, `busy` and `mem_req` are 0, and `ea` and `acc_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new address computation and word load |
| mode | input | 1 | 0: long register + disp8; 1: program-relative + disp16 |
| reg_idx | input | 2 | Long register select |
| disp8 | input | 8 | Signed 8-bit displacement |
| disp16 | input | 16 | 16-bit displacement |
| long_regs | input | 128 | Four packed 32-bit long registers |
| instr_addr | input | 16 | Address of the current instruction |
| prog_bank | input | 8 | Program bank register |
| acc_in | input | 32 | Accumulator value before the load |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 24 | Byte read address |
| mem_rdata | input | 8 | Byte read data, valid the cycle after the request |
| ea | output | 24 | Registered effective address |
| busy | output | 1 | Read sequence in progress |
| word_out | output | 16 | Fetched word |
| acc_out | output | 32 | Updated accumulator |
| done | output | 1 | One-cycle pulse when `acc_out` is updated |

## Verification
The checker watches the following on every cycle:
- the pairing of read requests, with the second address one above the first;
- that the first request uses the registered address;
- that the address holds steady while busy;
- that done is a single pulse and never overlaps busy;
- that the high byte of the word matches the data returned in the previous cycle.

Only the bench scenarios can show the address arithmetic itself, through random and edge operands:
- negative displacements;
- wrap of the 16-bit program-relative sum;
- the second-byte address wrapping past the 24-bit boundary;
- the accumulator half shift;
- that a start pulse and new operands during a busy sequence have no effect.

// File: rtl/eafu_pkg.sv
package eafu_pkg;

    localparam int ADDR_W  = 24;
    localparam int LREG_W  = 32;
    localparam int LREG_N  = 4;
    localparam int IDX_W   = $clog2(LREG_N);
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int ACC_W   = 2 * WORD_W;
    localparam int PC_W    = 16;
    localparam int BANK_W  = ADDR_W - PC_W;
    localparam int D8_W    = 8;
    localparam int D16_W   = 16;
    localparam logic [PC_W-1:0] PC_BIAS = PC_W'(4);

    typedef enum logic {
        AM_LONG_DISP = 1'b0,
        AM_PC_DISP   = 1'b1
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RD_LO = 2'd1,
        ST_RD_HI = 2'd2,
        ST_FIN   = 2'd3
    } rd_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } word_t;

    typedef struct packed {
        logic [WORD_W-1:0] upper;
        logic [WORD_W-1:0] lower;
    } acc_t;

    // long register plus sign-extended 8-bit displacement, low 24 bits kept
    function automatic logic [ADDR_W-1:0] long_disp_ea(
        input logic [LREG_W-1:0] base,
        input logic [D8_W-1:0]   disp
    );
        logic [LREG_W-1:0] sum;
        sum = base + {{(LREG_W-D8_W){disp[D8_W-1]}}, disp};
        return sum[ADDR_W-1:0];
    endfunction

    // bank byte on top, 16-bit wrapping sum of instruction address, bias, displacement below
    function automatic logic [ADDR_W-1:0] pc_disp_ea(
        input logic [BANK_W-1:0] bank,
        input logic [PC_W-1:0]   iaddr,
        input logic [D16_W-1:0]  disp
    );
        logic [PC_W-1:0] low;
        low = iaddr + PC_BIAS + disp;
        return {bank, low};
    endfunction

endpackage

// File: rtl/eafu_addr_calc.sv
module eafu_addr_calc
    import eafu_pkg::*;
(
    input  logic                      mode,
    input  logic [IDX_W-1:0]          reg_idx,
    input  logic [D8_W-1:0]           disp8,
    input  logic [D16_W-1:0]          disp16,
    input  logic [LREG_N*LREG_W-1:0]  long_regs,
    input  logic [PC_W-1:0]           instr_addr,
    input  logic [BANK_W-1:0]         prog_bank,
    output logic [ADDR_W-1:0]         ea_next
);

    logic [LREG_W-1:0] lreg_arr [LREG_N];

    for (genvar g = 0; g < LREG_N; g++) begin : g_unpack
        assign lreg_arr[g] = long_regs[g*LREG_W +: LREG_W];
    end

    logic [ADDR_W-1:0] ea_long;
    logic [ADDR_W-1:0] ea_pc;

    always_comb begin
        ea_long = long_disp_ea(lreg_arr[reg_idx], disp8);
        ea_pc   = pc_disp_ea(prog_bank, instr_addr, disp16);
        unique case (amode_e'(mode))
            AM_LONG_DISP: ea_next = ea_long;
            AM_PC_DISP:   ea_next = ea_pc;
            default:      ea_next = ea_long;
        endcase
    end

endmodule

// File: rtl/eafu_read_seq.sv
module eafu_read_seq
    import eafu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] ea_next,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              accept,
    output logic              busy,
    output logic [ADDR_W-1:0] ea_q,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              word_vld,
    output word_t             word
);

    rd_state_e         state_q;
    rd_state_e         state_d;
    logic [BYTE_W-1:0] lo_q;

    assign accept = start && (state_q == ST_IDLE);
    assign busy   = (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_RD_LO;
            ST_RD_LO: state_d = ST_RD_HI;
            ST_RD_HI: state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ea_q    <= '0;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                ea_q <= ea_next;
            end
            if (state_q == ST_RD_HI) begin
                lo_q <= mem_rdata;
            end
        end
    end

    always_comb begin
        mem_req  = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
        mem_addr = (state_q == ST_RD_HI) ? ea_q + ADDR_W'(1) : ea_q;
        word_vld = (state_q == ST_FIN);
        word.hi  = mem_rdata;
        word.lo  = lo_q;
    end

endmodule

// File: rtl/eafu_acc_update.sv
module eafu_acc_update
    import eafu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ACC_W-1:0]  acc_in,
    input  logic              word_vld,
    input  word_t             word,
    output logic [WORD_W-1:0] word_out,
    output logic [ACC_W-1:0]  acc_out,
    output logic              done
);

    logic [WORD_W-1:0] keep_q;
    acc_t              acc_q;
    acc_t              acc_src;

    assign acc_src = acc_t'(acc_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            keep_q   <= '0;
            acc_q    <= '0;
            word_out <= '0;
            done     <= 1'b0;
        end else begin
            done <= word_vld;
            if (accept) begin
                keep_q <= acc_src.lower;
            end
            if (word_vld) begin
                acc_q.upper <= keep_q;
                acc_q.lower <= word;
                word_out    <= word;
            end
        end
    end

    assign acc_out = acc_q;

endmodule

// File: rtl/ea_fetch_unit.sv
module ea_fetch_unit
    import eafu_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      mode,
    input  logic [IDX_W-1:0]          reg_idx,
    input  logic [D8_W-1:0]           disp8,
    input  logic [D16_W-1:0]          disp16,
    input  logic [LREG_N*LREG_W-1:0]  long_regs,
    input  logic [PC_W-1:0]           instr_addr,
    input  logic [BANK_W-1:0]         prog_bank,
    input  logic [ACC_W-1:0]          acc_in,
    output logic                      mem_req,
    output logic [ADDR_W-1:0]         mem_addr,
    input  logic [BYTE_W-1:0]         mem_rdata,
    output logic [ADDR_W-1:0]         ea,
    output logic                      busy,
    output logic [WORD_W-1:0]         word_out,
    output logic [ACC_W-1:0]          acc_out,
    output logic                      done
);

    logic [ADDR_W-1:0] ea_next;
    logic              accept;
    logic              word_vld;
    word_t             word;

    eafu_addr_calc u_calc (
        .mode       (mode),
        .reg_idx    (reg_idx),
        .disp8      (disp8),
        .disp16     (disp16),
        .long_regs  (long_regs),
        .instr_addr (instr_addr),
        .prog_bank  (prog_bank),
        .ea_next    (ea_next)
    );

    eafu_read_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .ea_next   (ea_next),
        .mem_rdata (mem_rdata),
        .accept    (accept),
        .busy      (busy),
        .ea_q      (ea),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .word_vld  (word_vld),
        .word      (word)
    );

    eafu_acc_update u_acc (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .acc_in   (acc_in),
        .word_vld (word_vld),
        .word     (word),
        .word_out (word_out),
        .acc_out  (acc_out),
        .done     (done)
    );

endmodule

// File: rtl/ea_fetch_unit_chk.sv
module ea_fetch_unit_chk
    import eafu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [BYTE_W-1:0] mem_rdata,
    input logic [ADDR_W-1:0] ea,
    input logic              busy,
    input logic [WORD_W-1:0] word_out,
    input logic              done
);

    // R3
    second_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R3
    first_addr_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> (mem_addr == ea));

    // R3
    req_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    // R4
    high_byte_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (word_out[WORD_W-1:BYTE_W] == $past(mem_rdata)));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7
    ea_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(ea));

    // R7
    start_take_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

endmodule

bind ea_fetch_unit ea_fetch_unit_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .ea        (ea),
    .busy      (busy),
    .word_out  (word_out),
    .done      (done)
);

// File: tb/ea_fetch_unit_tb_top.sv
module ea_fetch_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic         mode;
    logic [1:0]   reg_idx;
    logic [7:0]   disp8;
    logic [15:0]  disp16;
    logic [127:0] long_regs;
    logic [15:0]  instr_addr;
    logic [7:0]   prog_bank;
    logic [31:0]  acc_in;
    logic         mem_req;
    logic [23:0]  mem_addr;
    logic [7:0]   mem_rdata;
    logic [23:0]  ea;
    logic         busy;
    logic [15:0]  word_out;
    logic [31:0]  acc_out;
    logic         done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [23:0] ov_addr0 = 24'hFFFFFF;
    logic [7:0]  ov_data0 = 8'h00;
    logic [23:0] ov_addr1 = 24'hFFFFFF;
    logic [7:0]  ov_data1 = 8'h00;
    bit          ov_en    = 1'b0;

    int          req_cnt;
    logic [23:0] req_log [0:3];

    always #4 clk = ~clk;

    ea_fetch_unit dut_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .mode       (mode),
        .reg_idx    (reg_idx),
        .disp8      (disp8),
        .disp16     (disp16),
        .long_regs  (long_regs),
        .instr_addr (instr_addr),
        .prog_bank  (prog_bank),
        .acc_in     (acc_in),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .ea         (ea),
        .busy       (busy),
        .word_out   (word_out),
        .acc_out    (acc_out),
        .done       (done)
    );

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        if (ov_en && a == ov_addr0) return ov_data0;
        if (ov_en && a == ov_addr1) return ov_data1;
        return a[7:0] ^ {a[14:8], a[15]} ^ a[23:16] ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        if (mem_req) begin
            mem_rdata <= mem_byte(mem_addr);
            if (req_cnt < 4) req_log[req_cnt] <= mem_addr;
            req_cnt <= req_cnt + 1;
        end
    end

    function automatic logic [23:0] exp_long(input logic [31:0] r, input logic [7:0] d);
        logic [31:0] s;
        s = r + {{24{d[7]}}, d};
        return s[23:0];
    endfunction

    function automatic logic [23:0] exp_pc(input logic [7:0] b, input logic [15:0] ia,
                                           input logic [15:0] d);
        logic [15:0] lo;
        lo = ia + 16'd4 + d;
        return {b, lo};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic m, input logic [1:0] idx, input logic [7:0] d8,
                          input logic [15:0] d16, input logic [127:0] lr,
                          input logic [15:0] ia, input logic [7:0] bk,
                          input logic [31:0] accv, input bit poke);
        logic [23:0] xea;
        logic [15:0] xword;
        logic [31:0] xacc;
        xea   = m ? exp_pc(bk, ia, d16) : exp_long(lr[idx*32 +: 32], d8);
        xword = {mem_byte(xea + 24'd1), mem_byte(xea)};
        xacc  = {accv[15:0], xword};
        @(negedge clk);
        mode = m; reg_idx = idx; disp8 = d8; disp16 = d16; long_regs = lr;
        instr_addr = ia; prog_bank = bk; acc_in = accv; start = 1'b1;
        req_cnt = 0;
        @(negedge clk);
        start = 1'b0;
        // operands change after acceptance; must not matter (R7)
        mode = ~m; disp8 = ~d8; disp16 = ~d16; long_regs = ~lr;
        instr_addr = ia + 16'h1234; prog_bank = ~bk; acc_in = ~accv;
        chk(busy == 1'b1, "R7 busy after accept", 32'(busy), 32'd1);
        chk(ea == xea, m ? "R2 pc-relative ea" : "R1 long-register ea", 32'(ea), 32'(xea));
        if (poke) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R6 no early done", 32'(done), 32'd0);
        @(negedge clk);
        chk(done == 1'b0, "R6 no early done", 32'(done), 32'd0);
        chk(ea == xea, "R7 ea held while busy", 32'(ea), 32'(xea));
        @(negedge clk);
        chk(done == 1'b1, "R6 done timing", 32'(done), 32'd1);
        chk(word_out == xword, "R4 fetched word", 32'(word_out), 32'(xword));
        chk(acc_out == xacc, "R5 accumulator shift", acc_out, xacc);
        chk(req_cnt == 2, "R3 request count", 32'(req_cnt), 32'd2);
        chk(req_log[0] == xea, "R3 first byte address", 32'(req_log[0]), 32'(xea));
        chk(req_log[1] == xea + 24'd1, "R3 second byte address", 32'(req_log[1]),
            32'(xea + 24'd1));
        @(negedge clk);
        chk(done == 1'b0, "R6 done single pulse", 32'(done), 32'd0);
        chk(req_cnt == 2, "R7 no extra reads from ignored start", 32'(req_cnt), 32'd2);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; start = 1'b0; mode = 1'b0; reg_idx = '0; disp8 = '0; disp16 = '0;
        long_regs = '0; instr_addr = '0; prog_bank = '0; acc_in = '0; req_cnt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8
        chk(done == 1'b0, "R8 reset done", 32'(done), 32'd0);
        chk(busy == 1'b0, "R8 reset busy", 32'(busy), 32'd0);
        chk(mem_req == 1'b0, "R8 reset mem_req", 32'(mem_req), 32'd0);
        chk(ea == 24'd0, "R8 reset ea", 32'(ea), 32'd0);
        chk(acc_out == 32'd0, "R8 reset acc", acc_out, 32'd0);

        // R1 directed example: reg2 F3824B02 + 25 -> 824B27, bytes EE/FF -> FFEE, acc 0716_2534
        ov_en = 1'b1;
        ov_addr0 = 24'h824B27; ov_data0 = 8'hEE;
        ov_addr1 = 24'h824B28; ov_data1 = 8'hFF;
        run_op(1'b0, 2'd2, 8'h25, 16'h0, {32'h0, 32'hF3824B02, 32'h0, 32'h0},
               16'h0, 8'h0, 32'h0716_2534, 1'b0);
        chk(acc_out == 32'h2534_FFEE, "R5 example accumulator", acc_out, 32'h2534_FFEE);

        // R2 directed example: bank C5, ia 4556, disp 0020 -> C5457A
        ov_addr0 = 24'hC5457A; ov_data0 = 8'hEE;
        ov_addr1 = 24'hC5457B; ov_data1 = 8'hFF;
        run_op(1'b1, 2'd0, 8'h0, 16'h0020, '0, 16'h4556, 8'hC5, 32'h0716_2534, 1'b0);
        chk(ea == 24'hC5457A, "R2 example ea", 32'(ea), 32'hC5457A);
        ov_en = 1'b0;

        // R1 negative displacement, register 3
        run_op(1'b0, 2'd3, 8'h80, 16'h0, {32'h0000_0010, 96'h0}, 16'h0, 8'h0,
               32'hAAAA_5555, 1'b0);
        // R3 second byte wraps past 24 bits
        run_op(1'b0, 2'd0, 8'h00, 16'h0, {96'h0, 32'h12FF_FFFF}, 16'h0, 8'h0,
               32'h1111_2222, 1'b0);
        // R2 16-bit sum wraps without touching the bank
        run_op(1'b1, 2'd1, 8'h0, 16'h0002, '0, 16'hFFFE, 8'h7F, 32'h3333_4444, 1'b0);
        // R7 start pulsed while busy is ignored
        run_op(1'b1, 2'd0, 8'h0, 16'h8000, '0, 16'h1000, 8'h01, 32'hDEAD_BEEF, 1'b1);
        run_op(1'b0, 2'd1, 8'hFF, 16'h0, {32'h0, 32'h0, 32'h0000_0000, 32'h0}, 16'h0,
               8'h0, 32'h0, 1'b1);

        for (int i = 0; i < 60; i++) begin
            run_op(1'($urandom), 2'($urandom), 8'($urandom), 16'($urandom),
                   {$urandom, $urandom, $urandom, $urandom}, 16'($urandom),
                   8'($urandom), $urandom, 1'($urandom));
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule